// File: doc/BRIEF.md
# Frame Sync Window Protector

This block follows a raw frame-sync pattern detector in an optical disc read channel. It keeps frame timing with its own frame-length counter and checks each detected sync against an acceptance window around the tick where the next frame should begin. A sync inside the window is taken as genuine and realigns the counter. A sync outside it is ignored. If the expected tick passes with no sync, the block produces a synthetic frame strobe, so downstream logic keeps a steady frame rate through dropouts and jitter.

Synthetic strobes are counted. When the count of consecutive insertions reaches a programmable limit, the block gives up windowed protection and falls back to free acquisition. In that mode the next detected sync is accepted wherever it lands. Two status flags report the state. `locked_o` means the last accepted sync fell exactly on the expected tick. `windowed_o` means windowed protection is active. All timing is counted in channel-bit ticks, which are clock cycles with `bit_en` high.

Top module: `frame_sync_guard`

## Requirements
- R1: While reset is held and just after it is released, `frame_stb`, `locked_o` and `windowed_o` are all 0. The block therefore starts in free acquisition.
- R2: While `windowed_o` is 0, a tick with `sync_in` high is accepted wherever it falls. In the cycle after that tick, `frame_stb` is 1 and `windowed_o` is 1, and frame timing restarts from that tick.
- R3: A sync that arrives exactly FRAME_LEN ticks after the previous frame reference gives a strobe with `locked_o` = 1 and `windowed_o` = 1.
- R4: A sync at a distance d from the previous reference, with |d − FRAME_LEN| ≤ H and d ≠ FRAME_LEN, gives a strobe with `locked_o` = 0 and `windowed_o` = 1. Frame timing restarts from that sync.
- R5: While `windowed_o` is 1, a sync outside the window gives no strobe and does not move the frame timing.
- R6: The window half-width H is chosen by `win_sel`: 0 gives 3 ticks, 1 gives 7, 2 gives 13 and 3 gives 26 (the defaults of parameters HW0 to HW3).
- R7: If no sync arrives by the expected tick, a synthetic strobe is issued on that tick with `locked_o` = 0 and `windowed_o` = 1. The frame grid is kept, so the next expected tick is FRAME_LEN ticks later.
- R8: A sync arriving within H ticks after a synthetic strobe realigns the frame timing to itself and gives no additional strobe.
- R9: The insertion limit is `lim_coarse`·4 + `lim_fine` + 1. When the count of consecutive synthetic strobes reaches that limit, `windowed_o` falls H ticks after the last one, with no strobe on that cycle.
- R10: Any sync accepted as genuine clears the insertion count.
- R11: While `windowed_o` is 0 and no sync arrives, a synthetic strobe is issued every FRAME_LEN ticks with both flags 0. `locked_o` = 1 never occurs with `windowed_o` = 0.
- R12: Only cycles with `bit_en` high advance the timing. On a cycle with `bit_en` low, `sync_in` is ignored, no strobe is produced and the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Channel-bit tick enable |
| sync_in | input | 1 | Raw sync pulse from the pattern detector, sampled on ticks |
| win_sel | input | 2 | Window half-width select |
| lim_coarse | input | 2 | Insertion limit, counts of four |
| lim_fine | input | 2 | Insertion limit, single counts |
| frame_stb | output | 1 | One-cycle frame strobe, the cycle after an accepted or synthetic frame tick |
| locked_o | output | 1 | Last accepted sync coincided with the expected tick |
| windowed_o | output | 1 | Windowed protection active (0 = free acquisition) |

## Verification
The bench drives syncs in several patterns. Syncs exactly on the expected tick separate coincidence from window hits. Early syncs at the window edge and one tick beyond it, under two window selects, separate acceptance from rejection. Stray syncs far from the grid show that they are ignored. Dropped syncs followed by a late sync show realignment without a second strobe. Long dropout runs under two limit settings expose off-by-one errors in the limit. A genuine sync placed between insertion runs shows whether the count is cleared. A stretch with `bit_en` low and a sync inside it shows that gated cycles neither count nor accept.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    localparam int CFG_W   = 2;
    localparam int INS_MAX = 16;
    localparam int INS_W   = $clog2(INS_MAX + 1);

    typedef enum logic [2:0] {
        EV_IDLE,
        EV_COUNT,
        EV_ACCEPT,
        EV_REALIGN,
        EV_INSERT,
        EV_COMMIT,
        EV_FREE_ACCEPT,
        EV_FREE_INSERT
    } fsg_ev_e;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int pick4(input int i, input int a, input int b, input int c, input int d);
        case (i)
            0:       return a;
            1:       return b;
            2:       return c;
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/fsg_window.sv
module fsg_window
    import fsg_pkg::*;
#(
    parameter int FRAME_LEN = 588,
    parameter int HW0       = 3,
    parameter int HW1       = 7,
    parameter int HW2       = 13,
    parameter int HW3       = 26,
    parameter int CNT_W     = 10
) (
    input  logic [CFG_W-1:0] win_sel,
    input  logic [CNT_W-1:0] cur,
    output logic             in_win,
    output logic             at_exp,
    output logic             past_exp,
    output logic             at_close
);
    localparam logic [CNT_W-1:0] LEN_C = CNT_W'(FRAME_LEN);
    localparam int               N_SEL = 1 << CFG_W;

    logic [CNT_W-1:0] hw_tab [N_SEL];
    logic [CNT_W-1:0] half_w;
    logic [CNT_W-1:0] lo_edge;
    logic [CNT_W-1:0] hi_edge;

    for (genvar g = 0; g < N_SEL; g++) begin : g_tab
        assign hw_tab[g] = CNT_W'(pick4(g, HW0, HW1, HW2, HW3));
    end

    always_comb begin
        half_w   = hw_tab[win_sel];
        lo_edge  = LEN_C - half_w;
        hi_edge  = LEN_C + half_w;
        in_win   = (cur >= lo_edge) && (cur <= hi_edge);
        at_exp   = (cur == LEN_C);
        past_exp = (cur >= LEN_C);
        at_close = (cur >= hi_edge);
    end

endmodule

// File: rtl/fsg_limit.sv
module fsg_limit
    import fsg_pkg::*;
(
    input  logic [CFG_W-1:0] lim_coarse,
    input  logic [CFG_W-1:0] lim_fine,
    input  logic [INS_W-1:0] ins_cnt,
    output logic             reached
);
    logic [INS_W-1:0] limit;
    logic [INS_W-1:0] next_cnt;

    always_comb begin
        limit    = (INS_W'(lim_coarse) << 2) + INS_W'(lim_fine) + INS_W'(1);
        next_cnt = ins_cnt + INS_W'(1);
        reached  = (next_cnt >= limit);
    end

endmodule

// File: rtl/fsg_classify.sv
module fsg_classify
    import fsg_pkg::*;
(
    input  logic    tick,
    input  logic    sync,
    input  logic    windowed,
    input  logic    pend,
    input  logic    in_win,
    input  logic    past_exp,
    input  logic    at_close,
    output fsg_ev_e ev
);
    always_comb begin
        if (!tick) begin
            ev = EV_IDLE;
        end else if (!windowed) begin
            if (sync)          ev = EV_FREE_ACCEPT;
            else if (past_exp) ev = EV_FREE_INSERT;
            else               ev = EV_COUNT;
        end else if (sync && in_win) begin
            ev = pend ? EV_REALIGN : EV_ACCEPT;
        end else if (pend && at_close) begin
            ev = EV_COMMIT;
        end else if (!pend && past_exp) begin
            ev = EV_INSERT;
        end else begin
            ev = EV_COUNT;
        end
    end

endmodule

// File: rtl/frame_sync_guard.sv
module frame_sync_guard
    import fsg_pkg::*;
#(
    parameter int FRAME_LEN = 588,
    parameter int HW0       = 3,
    parameter int HW1       = 7,
    parameter int HW2       = 13,
    parameter int HW3       = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             sync_in,
    input  logic [CFG_W-1:0] win_sel,
    input  logic [CFG_W-1:0] lim_coarse,
    input  logic [CFG_W-1:0] lim_fine,
    output logic             frame_stb,
    output logic             locked_o,
    output logic             windowed_o
);
    localparam int               HW_MAX = max4(HW0, HW1, HW2, HW3);
    localparam int               CNT_W  = $clog2(FRAME_LEN + HW_MAX + 2);
    localparam logic [CNT_W-1:0] LEN_C  = CNT_W'(FRAME_LEN);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic [INS_W-1:0] ins;
        logic             pend;
        logic             stb;
        logic             locked;
        logic             windowed;
    } fsg_state_t;

    fsg_state_t s_q;
    fsg_state_t s_d;

    logic [CNT_W-1:0] cur_d;
    logic             in_win;
    logic             at_exp;
    logic             past_exp;
    logic             at_close;
    logic             lim_hit;
    fsg_ev_e          ev;

    assign cur_d = s_q.pos + CNT_W'(1);

    fsg_window #(
        .FRAME_LEN (FRAME_LEN),
        .HW0       (HW0),
        .HW1       (HW1),
        .HW2       (HW2),
        .HW3       (HW3),
        .CNT_W     (CNT_W)
    ) u_window (
        .win_sel  (win_sel),
        .cur      (cur_d),
        .in_win   (in_win),
        .at_exp   (at_exp),
        .past_exp (past_exp),
        .at_close (at_close)
    );

    fsg_limit u_limit (
        .lim_coarse (lim_coarse),
        .lim_fine   (lim_fine),
        .ins_cnt    (s_q.ins),
        .reached    (lim_hit)
    );

    fsg_classify u_classify (
        .tick     (bit_en),
        .sync     (sync_in),
        .windowed (s_q.windowed),
        .pend     (s_q.pend),
        .in_win   (in_win),
        .past_exp (past_exp),
        .at_close (at_close),
        .ev       (ev)
    );

    always_comb begin
        s_d     = s_q;
        s_d.stb = 1'b0;
        case (ev)
            EV_COUNT: begin
                s_d.pos = cur_d;
            end
            EV_ACCEPT, EV_FREE_ACCEPT: begin
                s_d.pos      = '0;
                s_d.stb      = 1'b1;
                s_d.locked   = at_exp;
                s_d.windowed = 1'b1;
                s_d.ins      = '0;
                s_d.pend     = 1'b0;
            end
            EV_REALIGN: begin
                s_d.pos  = '0;
                s_d.pend = 1'b0;
                s_d.ins  = '0;
            end
            EV_INSERT: begin
                s_d.pos    = cur_d;
                s_d.stb    = 1'b1;
                s_d.locked = 1'b0;
                s_d.pend   = 1'b1;
            end
            EV_COMMIT: begin
                s_d.pos  = cur_d - LEN_C;
                s_d.pend = 1'b0;
                if (lim_hit) begin
                    s_d.windowed = 1'b0;
                    s_d.ins      = '0;
                end else begin
                    s_d.ins = s_q.ins + INS_W'(1);
                end
            end
            EV_FREE_INSERT: begin
                s_d.pos    = '0;
                s_d.stb    = 1'b1;
                s_d.locked = 1'b0;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign frame_stb  = s_q.stb;
    assign locked_o   = s_q.locked;
    assign windowed_o = s_q.windowed;

endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic sync_in,
    input logic frame_stb,
    input logic locked_o,
    input logic windowed_o
);
    // R2
    free_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && sync_in && !windowed_o) |=> (frame_stb && windowed_o));

    // R12
    gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> (!frame_stb && $stable(locked_o) && $stable(windowed_o)));

    // R9
    drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(windowed_o) |-> !frame_stb);

    // R11
    lock_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> windowed_o);

    // R3
    lock_rise_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> frame_stb);

    // R2
    window_rise_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(windowed_o) |-> frame_stb);

endmodule

bind frame_sync_guard fsg_checker u_fsg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .sync_in    (sync_in),
    .frame_stb  (frame_stb),
    .locked_o   (locked_o),
    .windowed_o (windowed_o)
);

// File: tb/frame_sync_guard_bench.sv
`timescale 1ns / 1ps
module frame_sync_guard_bench;

    localparam int LEN = 100;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_en;
    logic       sync_in;
    logic [1:0] win_sel;
    logic [1:0] lim_coarse;
    logic [1:0] lim_fine;
    logic       frame_stb;
    logic       locked_o;
    logic       windowed_o;

    always #2 clk = ~clk;

    frame_sync_guard #(.FRAME_LEN(LEN)) u_frame_sync_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .sync_in    (sync_in),
        .win_sel    (win_sel),
        .lim_coarse (lim_coarse),
        .lim_fine   (lim_fine),
        .frame_stb  (frame_stb),
        .locked_o   (locked_o),
        .windowed_o (windowed_o)
    );

    typedef struct {
        int    edge_no;
        logic  lk;
        logic  wn;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   edge_n = 0;
    int   n_vec  = 0;
    int   n_bad  = 0;
    bit   run    = 1'b0;
    bit   done   = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) edge_n <= 0;
        else        edge_n <= edge_n + 1;
    end

    // monitor: every strobe must match the head of the scoreboard
    always @(negedge clk) begin
        if (run && frame_stb === 1'b1) begin
            exp_t it;
            n_vec++;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL R5 unexpected strobe: actual edge %0d, expected none", edge_n);
            end else begin
                it = sb.pop_front();
                if (it.edge_no != edge_n || it.lk !== locked_o || it.wn !== windowed_o) begin
                    n_bad++;
                    $display("FAIL %s: actual edge %0d locked %0b windowed %0b, expected edge %0d locked %0b windowed %0b",
                             it.tag, edge_n, locked_o, windowed_o, it.edge_no, it.lk, it.wn);
                end
            end
        end
    end

    task automatic at_edge(input int e, input logic s, input logic en = 1'b1);
        forever begin
            @(negedge clk);
            if (edge_n + 1 >= e) break;
            sync_in = 1'b0;
            bit_en  = 1'b1;
        end
        sync_in = s;
        bit_en  = en;
    endtask

    task automatic expect_stb(input int e, input logic lk, input logic wn, input string tag);
        exp_t it;
        it.edge_no = e;
        it.lk      = lk;
        it.wn      = wn;
        it.tag     = tag;
        sb.push_back(it);
    endtask

    task automatic sync_hit(input int e, input logic lk, input logic wn, input string tag);
        expect_stb(e, lk, wn, tag);
        at_edge(e, 1'b1);
    endtask

    task automatic sync_miss(input int e);
        at_edge(e, 1'b1);
    endtask

    task automatic check_win(input int e, input logic expv, input string tag);
        at_edge(e + 1, 1'b0);
        n_vec++;
        if (windowed_o !== expv) begin
            n_bad++;
            $display("FAIL %s: windowed_o after edge %0d actual %0b, expected %0b", tag, e, windowed_o, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        finish_run();
    end

    initial begin
        rst_n      = 1'b0;
        bit_en     = 1'b0;
        sync_in    = 1'b0;
        win_sel    = 2'd0;
        lim_coarse = 2'd0;
        lim_fine   = 2'd1;
        repeat (3) @(negedge clk);
        n_vec++;
        if (frame_stb !== 1'b0 || locked_o !== 1'b0 || windowed_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 in reset: actual stb %0b locked %0b windowed %0b, expected 0 0 0",
                     frame_stb, locked_o, windowed_o);
        end
        rst_n  = 1'b1;
        bit_en = 1'b1;
        run    = 1'b1;
        @(negedge clk);
        n_vec++;
        if (frame_stb !== 1'b0 || locked_o !== 1'b0 || windowed_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 after release: actual stb %0b locked %0b windowed %0b, expected 0 0 0",
                     frame_stb, locked_o, windowed_o);
        end

        // R2 free acquisition, then R3 exact and R4 early in window
        sync_hit(5,   1'b0, 1'b1, "R2 free accept");
        sync_hit(105, 1'b1, 1'b1, "R3 exact sync");
        sync_hit(203, 1'b0, 1'b1, "R4 early in window");
        // R5 stray sync ignored, timing unchanged
        sync_miss(293);
        sync_hit(303, 1'b1, 1'b1, "R5 timing kept after stray sync");
        // R7 insertion, R8 late realignment
        expect_stb(403, 1'b0, 1'b1, "R7 synthetic strobe");
        sync_miss(405);
        sync_hit(505, 1'b1, 1'b1, "R8 realigned to late sync");
        // R9 limit 2 (coarse 0, fine 1)
        expect_stb(605, 1'b0, 1'b1, "R7 first insertion");
        expect_stb(705, 1'b0, 1'b1, "R9 second insertion");
        check_win(707, 1'b1, "R9 before limit commit");
        check_win(708, 1'b0, "R9 limit reached");
        // R11 free-mode insertion, then free accept
        expect_stb(805, 1'b0, 1'b0, "R11 free insertion");
        sync_hit(830, 1'b0, 1'b1, "R2 free accept off grid");
        // R10 count cleared by a genuine sync
        expect_stb(930, 1'b0, 1'b1, "R7 insertion before clear");
        sync_hit(1030, 1'b1, 1'b1, "R10 genuine sync on grid");
        expect_stb(1130, 1'b0, 1'b1, "R10 insertion after clear");
        check_win(1134, 1'b1, "R10 window kept after clear");
        sync_hit(1230, 1'b1, 1'b1, "R7 grid kept after insertion");
        // R6 wide window, then narrow window boundary
        at_edge(1309, 1'b0);
        win_sel = 2'd3;
        sync_hit(1310, 1'b0, 1'b1, "R6 wide window accept");
        at_edge(1330, 1'b0);
        win_sel = 2'd0;
        sync_miss(1406);
        sync_hit(1407, 1'b0, 1'b1, "R6 narrow window edge");
        // R9 limit 7 (coarse 1, fine 2)
        at_edge(1420, 1'b0);
        lim_coarse = 2'd1;
        lim_fine   = 2'd2;
        for (int k = 0; k < 7; k++) begin
            expect_stb(1507 + 100 * k, 1'b0, 1'b1, "R9 insertion run");
        end
        check_win(2109, 1'b1, "R9 sixth insertion keeps window");
        check_win(2110, 1'b0, "R9 seventh insertion drops window");
        sync_hit(2150, 1'b0, 1'b1, "R2 reacquire");
        // R12 gated ticks do not count and ignore syncs
        for (int e = 2180; e < 2190; e++) begin
            at_edge(e, (e == 2185) ? 1'b1 : 1'b0, 1'b0);
        end
        sync_hit(2260, 1'b1, 1'b1, "R12 gated ticks not counted");
        at_edge(2270, 1'b0);

        while (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            n_vec++;
            n_bad++;
            $display("FAIL %s: actual no strobe, expected strobe at edge %0d", it.tag, it.edge_no);
        end
        finish_run();
    end

endmodule